// File: doc/BRIEF.md
# Constant-Coefficient Signed Multiplier with Two-Bit Radix-4 Digits

This block multiplies a two's complement sample by one of a small set of fixed signed coefficients. The coefficients are converted to radix-4 signed digits while the design elaborates. Each digit takes one of four values and is kept in a read-only table as exactly two bits. At run time no recoding happens. The sample and a coefficient index arrive together with a valid strobe. The table returns the digit word for that index, and one small selector per digit turns its two bits into a partial product of 0, ±X or ±2X. The partial products are weighted by 4^j, summed, and registered.

The `NEG_HIGH` parameter picks the digit convention. With `NEG_HIGH=1` the high bit of a digit weighs -2 and the low bit +1, so the digit set is {-2,-1,0,1}. With `NEG_HIGH=0` the high bit weighs +2 and the low bit -1, so the digit set is {-1,0,1,2}.

A CW-bit coefficient uses CW/2+1 digits. The one extra top digit lets every signed CW-bit value be written exactly in either convention, including the most negative one.

Top module: `nr4_coef_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `out_valid`=0 and `out_prod`=0.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high at the clock edge.
- R3: For an accepted input, `out_prod` in the next cycle equals the signed product of `in_x` and coefficient `in_idx` from `COEF_TABLE`, as an XW+CW bit two's complement value. Entry i occupies bits [i*CW +: CW] of `COEF_TABLE`.
- R4: When `in_valid` is low, `out_prod` keeps its value, whatever `in_x` and `in_idx` carry.
- R5: An index of NCOEF or more selects a zero coefficient, so the product is 0.
- R6: With `NEG_HIGH=1`, digit j sits in code bits [2j+1:2j] with the high bit at the odd position. The codes decode as 00=0, 01=+1, 10=-2, 11=-1, and each partial product equals digit·X.
- R7: With `NEG_HIGH=0`, the codes decode as 00=0, 01=-1, 10=+2, 11=+1, and products match R3 in this convention too.
- R8: The extreme coefficients -2^(CW-1) and 2^(CW-1)-1 reconstruct exactly through the top digit, giving correct products for every X.
- R9: The most negative X times the most negative coefficient gives +2^(XW+CW-2) with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_x | input | XW | Signed sample |
| in_idx | input | IW = clog2(NCOEF) | Coefficient index |
| out_valid | output | 1 | Product valid, one cycle after `in_valid` |
| out_prod | output | XW+CW | Registered signed product |

## Verification
The hardest cases to reach are those where the top digit carries the coefficient's sign while a partial product must negate 2X of the most negative sample. That negation only fits because of the spare partial-product bit and the separately added correction bit. The stimulus drives -2^(XW-1) and 2^(XW-1)-1 against every table entry, including both extreme coefficients and one index past the table. Seeded random samples and indices then cover the remaining digit mixes. Two instances, one per convention, receive the same stimulus so that both decoders are compared against the same behavioural product.

// File: rtl/nr4_pkg.sv
// Package: digit code mapping shared by the table builder, selectors and checks.
// Assumes a digit code is {high bit, low bit}; neg_high selects the convention.
package nr4_pkg;

    // Two-bit code for the digit whose value is congruent to resid modulo 4.
    function automatic logic [1:0] digit_code(input logic neg_high, input logic [1:0] resid);
        logic [1:0] c;
        if (neg_high) begin
            c = resid;                 // 0->00, 1->01, -2->10, -1->11
        end else begin
            case (resid)
                2'd0:    c = 2'b00;
                2'd1:    c = 2'b11;    // +1
                2'd2:    c = 2'b10;    // +2
                default: c = 2'b01;    // -1
            endcase
        end
        return c;
    endfunction

    // Signed value carried by a two-bit code.
    function automatic int code_value(input logic neg_high, input logic [1:0] code);
        if (neg_high) return int'(code[0]) - 2 * int'(code[1]);
        return 2 * int'(code[1]) - int'(code[0]);
    endfunction

endpackage

// File: rtl/nr4_coef_rom.sv
// Coefficient table: encodes each signed CW-bit entry of COEF_TABLE into ND
// two-bit digits at elaboration, and returns the digit word for an index.
// Assumes ND digits are enough for every entry (ND = CW/2+1 is).
// An index at or past NCOEF returns all-zero digits.
module nr4_coef_rom #(
    parameter int          CW         = 8,
    parameter int          ND         = 5,
    parameter int          NCOEF      = 7,
    parameter int          IW         = 3,
    parameter bit          NEG_HIGH   = 1'b1,
    parameter logic [NCOEF*CW-1:0] COEF_TABLE = '0
) (
    input  logic [IW-1:0]   idx,
    output logic [2*ND-1:0] code
);
    import nr4_pkg::*;

    // Elaboration-time digit recurrence: peel off one radix-4 digit per step.
    function automatic logic [2*ND-1:0] encode(input logic signed [CW-1:0] c);
        int v;
        logic [2*ND-1:0] w;
        logic [1:0] cd;
        v = int'(c);
        w = '0;
        for (int j = 0; j < ND; j++) begin
            cd = digit_code(NEG_HIGH, v[1:0]);
            w[2*j +: 2] = cd;
            v = (v - code_value(NEG_HIGH, cd)) >>> 2;
        end
        return w;
    endfunction

    logic [2*ND-1:0] table_w [NCOEF];

    for (genvar e = 0; e < NCOEF; e++) begin : g_entry
        localparam logic [2*ND-1:0] ENC = encode(COEF_TABLE[e*CW +: CW]);
        assign table_w[e] = ENC;
    end

    // Table read with a zero coefficient for indices beyond the table.
    always_comb begin
        code = '0;
        if (int'(idx) < NCOEF) code = table_w[idx];
    end

endmodule

// File: rtl/nr4_pp_gen.sv
// Partial-product selector for one digit: returns 0, X or 2X, bit-inverted
// when the digit is negative, plus a separate +1 correction flag.
// Assumes pp is later summed with neg at the same weight.
module nr4_pp_gen #(
    parameter int XW       = 8,
    parameter bit NEG_HIGH = 1'b1
) (
    input  logic [XW-1:0] x,
    input  logic [1:0]    code,
    output logic [XW+1:0] pp,
    output logic          neg
);
    localparam int PPW = XW + 2;

    logic sel1, sel2;
    logic [PPW-1:0] mag;

    // Sign of the digit depends on the convention.
    if (NEG_HIGH) begin : g_neg_high
        assign neg = code[1];
    end else begin : g_pos_high
        assign neg = code[0] & ~code[1];
    end

    assign sel2 = code[1] & ~code[0];
    assign sel1 = code[0];

    // Magnitude select followed by conditional inversion.
    always_comb begin
        mag = '0;
        if (sel2)      mag = {x[XW-1], x, 1'b0};
        else if (sel1) mag = {{2{x[XW-1]}}, x};
        pp = mag ^ {PPW{neg}};
    end

endmodule

// File: rtl/nr4_pp_sum.sv
// Weighted sum of ND partial products: each one sign-extended, shifted by 2j,
// with its negation correction added at the same weight. Result taken mod 2^PW.
// Assumes PW > PPW.
module nr4_pp_sum #(
    parameter int ND  = 5,
    parameter int PPW = 10,
    parameter int PW  = 16
) (
    input  logic [ND*PPW-1:0] pp_flat,
    input  logic [ND-1:0]     neg,
    output logic [PW-1:0]     sum
);
    logic [PW-1:0] ext;

    // Accumulate shifted partial products and their +1 corrections.
    always_comb begin
        sum = '0;
        for (int j = 0; j < ND; j++) begin
            ext = {{(PW-PPW){pp_flat[j*PPW+PPW-1]}}, pp_flat[j*PPW +: PPW]};
            sum = sum + (ext << (2*j)) + (PW'(neg[j]) << (2*j));
        end
    end

endmodule

// File: rtl/nr4_coef_mul.sv
// Top: multiplies signed in_x by table coefficient in_idx using stored
// two-bit radix-4 digits; the product is registered one cycle after in_valid.
// Assumes CW even, CW >= 4, and XW+CW <= 32.
module nr4_coef_mul #(
    parameter int XW         = 8,
    parameter int CW         = 8,
    parameter int NCOEF      = 7,
    parameter bit NEG_HIGH   = 1'b1,
    parameter logic [NCOEF*CW-1:0] COEF_TABLE =
        {8'hAA, 8'h55, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00},
    localparam int IW = (NCOEF > 1) ? $clog2(NCOEF) : 1,
    localparam int PW = XW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    input  logic [IW-1:0] in_idx,
    output logic          out_valid,
    output logic [PW-1:0] out_prod
);
    localparam int ND  = CW / 2 + 1;
    localparam int PPW = XW + 2;

    logic [2*ND-1:0]   code_w;
    logic [ND*PPW-1:0] pp_w;
    logic [ND-1:0]     neg_w;
    logic [PW-1:0]     sum_w;

    nr4_coef_rom #(
        .CW(CW), .ND(ND), .NCOEF(NCOEF), .IW(IW),
        .NEG_HIGH(NEG_HIGH), .COEF_TABLE(COEF_TABLE)
    ) rom_i (
        .idx (in_idx),
        .code(code_w)
    );

    for (genvar j = 0; j < ND; j++) begin : g_digit
        nr4_pp_gen #(.XW(XW), .NEG_HIGH(NEG_HIGH)) pp_i (
            .x   (in_x),
            .code(code_w[2*j +: 2]),
            .pp  (pp_w[j*PPW +: PPW]),
            .neg (neg_w[j])
        );

        AST_DIGIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (int'($signed(pp_w[j*PPW +: PPW])) + int'(neg_w[j]))
                == nr4_pkg::code_value(NEG_HIGH, code_w[2*j +: 2]) * int'($signed(in_x))); // R6 R7
    end

    nr4_pp_sum #(.ND(ND), .PPW(PPW), .PW(PW)) sum_i (
        .pp_flat(pp_w),
        .neg    (neg_w),
        .sum    (sum_w)
    );

    // Output register: capture the sum on a valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_prod <= sum_w;
        end
    end

    // Behavioural reference coefficient, used only by the checks below.
    function automatic int coef_at(input logic [IW-1:0] i);
        if (int'(i) >= NCOEF) return 0;
        return int'($signed(COEF_TABLE[int'(i)*CW +: CW]));
    endfunction

    logic [PW-1:0] ref_w;
    always_comb ref_w = PW'(int'($signed(in_x)) * coef_at(in_idx));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_prod == '0)); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_prod == $past(ref_w)); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod)); // R4
    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_idx) >= NCOEF) |=> out_prod == '0); // R5

endmodule

// File: tb/nr4_coef_mul_tb.sv
`timescale 1ns/1ps
// Bench: two instances (one per digit convention) driven by the same
// directed and seeded random stimulus, checked against a behavioural product.
module nr4_coef_mul_tb_top;
    localparam int XW = 8;
    localparam int CW = 8;
    localparam int NCOEF = 7;
    localparam int IW = 3;
    localparam int PW = XW + CW;
    localparam logic [NCOEF*CW-1:0] TAB =
        {8'hAA, 8'h55, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [IW-1:0] in_idx = '0;
    logic vld_n, vld_p;
    logic [PW-1:0] prod_n, prod_p;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    nr4_coef_mul #(.XW(XW), .CW(CW), .NCOEF(NCOEF), .NEG_HIGH(1'b1), .COEF_TABLE(TAB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .out_valid(vld_n), .out_prod(prod_n));

    nr4_coef_mul #(.XW(XW), .CW(CW), .NCOEF(NCOEF), .NEG_HIGH(1'b0), .COEF_TABLE(TAB)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .out_valid(vld_p), .out_prod(prod_p));

    // Bench copy of the table: -86, 85, -128, 127, -1, 1, 0 from the top.
    function automatic int coef(input int i);
        int c [NCOEF] = '{0, 1, -1, 127, -128, 85, -86};
        if (i >= NCOEF) return 0;
        return c[i];
    endfunction

    function automatic int wrap(input int v);
        logic signed [PW-1:0] t;
        t = PW'(v);
        return int'(t);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One accepted operation, checked on both instances one cycle later.
    task automatic op(input logic [XW-1:0] x, input logic [IW-1:0] idx);
        int e;
        string tag;
        @(negedge clk);
        in_valid = 1'b1; in_x = x; in_idx = idx;
        @(negedge clk);
        in_valid = 1'b0;
        e = wrap(int'($signed(x)) * coef(int'(idx)));
        tag = "R3";
        if (int'(idx) >= NCOEF) tag = "R5";
        else if (coef(int'(idx)) == -128 || coef(int'(idx)) == 127) tag = "R8";
        if ($signed(x) == -128 && coef(int'(idx)) == -128) tag = "R9";
        chk({tag, "/R6"}, int'($signed(prod_n)), e);
        chk({tag, "/R7"}, int'($signed(prod_p)), e);
        chk("R2 valid", int'(vld_n) + int'(vld_p), 2);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int last;
        logic [XW-1:0] xs [4] = '{8'h80, 8'h7F, 8'hFF, 8'h01};
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(vld_n) + int'(vld_p), 0);
        chk("R1 prod", int'(prod_n) + int'(prod_p), 0);
        rst_n = 1'b1;

        // Directed: extreme and unit samples against every index, including one past the table.
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 8; i++)
                op(xs[k], IW'(i));

        op(8'h80, 3'd4);   // R9: -128 * -128 = 16384
        chk("R9 value", int'($signed(prod_n)), 16384);

        // R4: idle cycle with changed inputs must not disturb the product.
        op(8'h37, 3'd5);
        last = wrap(55 * 85);
        @(negedge clk);
        in_x = 8'hC3; in_idx = 3'd6;
        @(negedge clk);
        chk("R4 hold/R6", int'($signed(prod_n)), last);
        chk("R4 hold/R7", int'($signed(prod_p)), last);
        chk("R2 idle", int'(vld_n) + int'(vld_p), 0);

        // Seeded random operations.
        for (int n = 0; n < 400; n++)
            op(XW'($urandom), IW'($urandom % 8));

        // R1: reset mid-run clears the outputs.
        op(8'h7F, 3'd3);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R1 mid valid", int'(vld_n) + int'(vld_p), 0);
        chk("R1 mid prod", int'(prod_n) + int'(prod_p), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule